// File: doc/BRIEF.md
# Multi-stride sequential left shifter

This block is a multi-cycle logical left shifter. It does not build a full barrel shifter. It keeps two fixed-distance shift stages and reuses them over several clock cycles. The coarse stage moves the word by four places and the fine stage moves it by one place (default configuration). The remaining shift is held as two separate count segments, one per stage. In every cycle each stage is applied or bypassed according to its own segment. A shift by 9 therefore becomes two coarse moves and one fine move, and it completes in two cycles.

A pulse on `start` loads the word and the amount. The caller then waits for `ready` to return high and reads `data_out`. A new `start` may be issued at any time, and it abandons whatever work is in flight. Control is plain strobe and level signalling. There is no back-pressure: the result simply stays in its register until the next `start`.

Top module: `mss_shifter`

## Requirements
- R1: When `start` is high at a rising clock edge, `data_out` holds `data_in` from that edge in the following cycle, whatever the block was doing before.
- R2: `ready` is high exactly when both count segments are zero. After a `start` with a nonzero amount it is low in the next cycle. After a `start` with amount 0 it stays high.
- R3: Once `ready` is high again, `data_out` equals the loaded word shifted left by the amount, truncated to WIDTH bits, with the vacated low bits filled with zeros.
- R4: The coarse segment loads from `amount[3:2]` and the fine segment loads from `amount[1:0]`. `ready` rises exactly max(amount[3:2], amount[1:0]) cycles after the loading edge.
- R5: A `start` while an operation is in progress discards that operation and loads the new word and amount.
- R6: While `ready` is high and `start` is low, `data_out` and `ready` hold their values.
- R7: While `rst_n` is low, `data_out` is zero and `ready` is high.
- R8: In the j-th cycle after loading, `data_out` is the loaded word shifted left by 4*min(j, amount[3:2]) + min(j, amount[1:0]). In any one cycle the coarse stage is applied first and then the fine stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load strobe for a new word and amount |
| amount | input | WIDTH_LG (4) | Shift distance in places |
| data_in | input | WIDTH (16) | Word to be shifted |
| data_out | output | WIDTH (16) | Registered shifted word |
| ready | output | 1 | High when no shift work remains |

## Verification
The bench builds the block with its default WIDTH_LG of 4, which gives a 16-bit word and 2-bit segments. With this size every one of the 16 shift amounts can be swept against several data patterns, including all-ones and single-bit words that expose truncation and zero fill. Because the sweep is complete, every intermediate cycle of every segment combination is compared with an arithmetic model, along with every exact latency. Restarts in the middle of an operation, both to a nonzero amount and to amount 0, cover the priority of a new `start`.

// File: rtl/mss_pkg.sv
package mss_pkg;
  localparam int unsigned NUM_STAGES = 2;

  // Place count moved by stage idx: stage 0 is the coarse stride.
  function automatic int unsigned stride_of(input int unsigned idx, input int unsigned lo_bits);
    return (idx == 0) ? (1 << lo_bits) : 1;
  endfunction
endpackage

// File: rtl/mss_fixed_stage.sv
module mss_fixed_stage #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STRIDE = 1
) (
  input  logic             apply,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned KEEP = WIDTH - STRIDE;

  logic [WIDTH-1:0] moved;

  // Pure bit renaming upward with zero fill of the vacated low positions.
  assign moved = {din[KEEP-1:0], {STRIDE{1'b0}}};
  assign dout  = apply ? moved : din;
endmodule

// File: rtl/mss_seg_counter.sv
module mss_seg_counter #(
  parameter int unsigned SEG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_W-1:0] load_val,
  output logic             active,
  output logic [SEG_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (active) cnt <= cnt - SEG_W'(1);
  end

  assign active = (cnt != '0);

  // R4: each active segment steps down by one per cycle
  a_r4_seg_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && active) |=> (cnt == $past(cnt) - SEG_W'(1)));

  // R6: an idle segment stays idle until loaded
  a_r6_seg_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !active) |=> !active);
endmodule

// File: rtl/mss_shifter.sv
module mss_shifter
  import mss_pkg::*;
#(
  parameter int unsigned WIDTH_LG = 4,
  parameter int unsigned WIDTH    = 1 << WIDTH_LG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WIDTH_LG-1:0] amount,
  input  logic [WIDTH-1:0]    data_in,
  output logic [WIDTH-1:0]    data_out,
  output logic                ready
);
  localparam int unsigned LO_BITS = WIDTH_LG / 2;
  localparam int unsigned HI_BITS = WIDTH_LG - LO_BITS;
  localparam int unsigned SEG_W   = HI_BITS;

  logic [WIDTH-1:0]      chain      [NUM_STAGES+1];
  logic [SEG_W-1:0]      seg_load   [NUM_STAGES];
  logic [SEG_W-1:0]      seg_cnt    [NUM_STAGES];
  logic [NUM_STAGES-1:0] seg_active;
  logic [WIDTH-1:0]      data_q;

  assign chain[0] = data_q;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    localparam int unsigned STRIDE = stride_of(i, LO_BITS);

    if (i == 0) begin : g_coarse
      assign seg_load[i] = amount[WIDTH_LG-1:LO_BITS];
    end else begin : g_fine
      assign seg_load[i] = SEG_W'(amount[LO_BITS-1:0]);
    end

    mss_seg_counter #(.SEG_W(SEG_W)) u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_val (seg_load[i]),
      .active   (seg_active[i]),
      .cnt      (seg_cnt[i])
    );

    mss_fixed_stage #(.WIDTH(WIDTH), .STRIDE(STRIDE)) u_stage (
      .apply (seg_active[i]),
      .din   (chain[i]),
      .dout  (chain[i+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (start) data_q <= data_in;
    else            data_q <= chain[NUM_STAGES];
  end

  assign data_out = data_q;
  assign ready    = (seg_active == '0);

  // R1, R5: a start always loads the word, even mid-operation
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (data_out == $past(data_in)));

  // R2: nonzero amount makes the block busy on the next cycle
  a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && amount != '0) |=> !ready);

  // R2: zero amount leaves the block ready
  a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && amount == '0) |=> ready);

  // R6: idle result holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ($stable(data_out) && ready));

  // R3: bits below the shifted-in zeros never become set while shifting
  a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && $past(data_out[0]) == 1'b0) |-> (data_out[0] == 1'b0 || $past(start)));
endmodule

// File: tb/tb_mss_shifter.sv
module tb_mss_shifter;
  localparam int unsigned WL = 4;
  localparam int unsigned W  = 1 << WL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [WL-1:0] amount = '0;
  logic [W-1:0]  data_in = '0;
  logic [W-1:0]  data_out;
  logic          ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mss_shifter #(.WIDTH_LG(WL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .amount(amount),
    .data_in(data_in), .data_out(data_out), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned imin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Loads at the next rising edge; returns at the negedge after it.
  task automatic load(input logic [W-1:0] d, input logic [WL-1:0] a);
    @(negedge clk);
    start = 1'b1; data_in = d; amount = a;
    @(negedge clk);
    start = 1'b0;
    check(data_out == d, "R1 load", data_out, d);
    check(ready == (a == 0), "R2 ready after load", W'(ready), W'(a == 0));
  endtask

  task automatic run_op(input logic [W-1:0] d, input logic [WL-1:0] a);
    int unsigned hi, lo, lat;
    logic [W-1:0] exp;
    hi = a >> 2; lo = a & 3; lat = (hi > lo) ? hi : lo;
    load(d, a);
    for (int unsigned j = 1; j <= lat; j++) begin
      @(negedge clk);
      exp = d << (4 * imin(j, hi) + imin(j, lo));
      check(data_out == exp, "R8 intermediate", data_out, exp);
      check(ready == (j == lat), "R4 latency", W'(ready), W'(j == lat));
    end
    exp = d << a;
    check(data_out == exp, "R3 result", data_out, exp);
    @(negedge clk);
    check(data_out == exp && ready, "R6 hold", data_out, exp);
  endtask

  initial begin
    logic [W-1:0] pats [6];
    pats[0] = 16'hFFFF; pats[1] = 16'h8001; pats[2] = 16'hA5C3;
    pats[3] = 16'h1234; pats[4] = 16'h0001; pats[5] = 16'h7E18;

    #1;
    @(negedge clk);
    check(data_out == '0, "R7 reset data", data_out, '0);
    check(ready == 1'b1, "R7 reset ready", W'(ready), W'(1));
    start = 1'b1; data_in = 16'hBEEF; amount = 4'd5;
    @(negedge clk);
    check(data_out == '0 && ready, "R7 start ignored in reset", data_out, '0);
    start = 1'b0;
    rst_n = 1'b1;

    for (int p = 0; p < 6; p++)
      for (int a = 0; a < 16; a++)
        run_op(pats[p], WL'(a));

    // R5: restart mid-operation with a nonzero amount
    load(16'h00F1, 4'd15);
    @(negedge clk);
    run_op(16'h0C35, 4'd6);

    // R5: restart mid-operation with amount 0
    load(16'h4321, 4'd11);
    run_op(16'h9A9A, 4'd0);

    // R6: idle for several cycles
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(data_out == 16'h9A9A && ready, "R6 idle", data_out, 16'h9A9A);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule